// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital controller that sits in front of a 10-bit successive-approximation converter. It decides which input is converted next, starts the converter through a start/done handshake, and files each returned sample into a result store. Sixteen inputs are wired straight to the converter. Eight further inputs reach it through an external 1-of-8 analog multiplexer that hangs off one dedicated converter input, and the block drives that multiplexer's select lines on its own.

Software programs the sequence over a simple synchronous register bus. It chooses the channels that take part in a normal chain and those in a high-priority injected chain, and it picks one-shot or continuous scan. A chain starts on a software command or on a pulse from a periodic timer. An injected chain slips in between normal conversions and the normal chain then carries on where it stopped.

Each result word gives the aligned sample in its low half and an injected-origin flag in its upper half. Four window comparators watch chosen channels and latch alarms. A power-down bit halts everything.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Within a chain, the enabled channels (mask register at word address 2; bit n selects logical channel n, where channels 0 to 15 are internal and 16 to 23 are external) are converted once each, in ascending logical order. In one-shot mode (control bit 0 clear) the block then stops.
- R2: With control bit 0 set (scan), a normal chain restarts from the lowest enabled channel after its last channel completes. Every chain end sets the sticky end-of-chain flag (status bit 1, write 1 to clear).
- R3: Command bit 1 (word address 1) loads the injected chain from the mask at word address 3. It waits for the conversion in flight to finish, runs ahead of the remaining normal channels, and then the normal chain resumes at its next unconverted channel. Results it writes carry bit 16 = 1, normal results carry bit 16 = 0, and its end sets status bit 2.
- R4: Logical channel 16+k is converted on converter input 16 with the external select equal to k. Its result lands in the single shared result word at address 32. Internal channel n uses converter input n, the select reads 0, and the result goes to address 16+n.
- R5: Result bits [15:0] hold the 10-bit sample right-aligned when control bit 1 is 0, and shifted left by 6 when it is 1.
- R6: Comparator k (address 8+k) holds low [9:0], high [19:10], channel [24:20] and mode [26:25]. Mode 1 fires when the sample is above high, mode 2 when it is below low, mode 3 on either, and mode 0 never fires. A hit sets sticky alarm k, seen on the `alarm` port and in status bit 8+k, and writing 1 to that status bit clears it.
- R7: A `timerTick` pulse starts a normal chain only while control bit 3 is set. Otherwise it is ignored.
- R8: While control bit 2 (power-down) is set, no conversion starts, pending chains are discarded, start commands are ignored, and `busy` is low.
- R9: `convStart` is a one-cycle pulse, `busy` is high while a conversion is outstanding, and the converter input index never exceeds 16.
- R10: After reset, all registers, results, alarms and flags read 0, and `convStart` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 6 | Register word address |
| regWr | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, registered, for the address of the previous cycle |
| timerTick | input | 1 | Periodic timer trigger pulse |
| convStart | output | 1 | Start pulse to the converter |
| convChan | output | 5 | Converter input index |
| extSel | output | 3 | External multiplexer select |
| convDone | input | 1 | Conversion complete pulse |
| convData | input | 10 | Converted sample |
| alarm | output | 4 | Sticky comparator alarms |
| busy | output | 1 | Conversion or chain pending |

## Verification
Several properties are checked on every cycle. `convStart` is a single-cycle pulse that implies `busy`. No start follows a cycle in power-down. The external select stays at zero for internal conversions. An alarm never drops without a write-one-clear. Conversion order, the point at which a normal chain resumes after an injection, the injected-origin flag, alignment, shared external storage and comparator thresholds are only visible across whole scenarios. The bench shows them by sweeping channel masks and comparing the logged start order and every read-back word against values it computes from the sample formula.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_INT   = 16;
  localparam int NUM_EXT   = 8;
  localparam int DATA_W    = 10;
  localparam int NUM_CMP   = 4;
  localparam int ADDR_W    = 6;
  localparam int RES_W     = 16;

  localparam int NUM_CH    = NUM_INT + NUM_EXT;
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int SEL_W     = $clog2(NUM_EXT);
  localparam int CONV_CH_W = $clog2(NUM_INT + 1);
  localparam int NUM_RES   = NUM_INT + 1;
  localparam int PAD_W     = RES_W - DATA_W;

  localparam int A_CTRL    = 0;
  localparam int A_CMD     = 1;
  localparam int A_NMASK   = 2;
  localparam int A_IMASK   = 3;
  localparam int A_STAT    = 4;
  localparam int A_CMP     = 8;
  localparam int A_RES     = 16;
  localparam int STAT_ALM  = 8;

  localparam int CMP_HI_LSB   = DATA_W;
  localparam int CMP_CH_LSB   = 2 * DATA_W;
  localparam int CMP_MODE_LSB = 2 * DATA_W + CH_W;
  localparam int CMP_TOP      = CMP_MODE_LSB + 2;

  typedef enum logic [1:0] {
    CMP_OFF  = 2'd0,
    CMP_GT   = 2'd1,
    CMP_LT   = 2'd2,
    CMP_OUTR = 2'd3
  } cmp_mode_t;

  typedef struct packed {
    logic              scanMode;
    logic              powerDown;
    logic              timerEn;
    logic [NUM_CH-1:0] normMask;
    logic [NUM_CH-1:0] injMask;
    logic              swStart;
    logic              swInject;
  } seq_cfg_t;

  typedef struct packed {
    logic              resWr;
    logic              resInj;
    logic [CH_W-1:0]   resChan;
    logic [DATA_W-1:0] resData;
    logic              normEoc;
    logic              injEoc;
    logic              busy;
  } seq_strobe_t;
endpackage

// File: rtl/adc_seq_ctrl_fsm.sv
module adc_seq_ctrl_fsm
  import adc_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  seq_cfg_t             cfg,
  input  logic                 timerTick,
  input  logic                 convDone,
  input  logic [DATA_W-1:0]    convData,
  output logic                 convStart,
  output logic [CONV_CH_W-1:0] convChan,
  output logic [SEL_W-1:0]     extSel,
  output seq_strobe_t          strobe
);
  typedef enum logic {ST_IDLE, ST_CONV} state_t;

  state_t            state;
  logic [NUM_CH-1:0] normPend, injPend, normPendN, injPendN;
  logic [CH_W-1:0]   curIdx, pickIdx;
  logic              curInj, pickInj, launch;
  logic              normActive, injActive, doneHit, trigNorm, trigInj;
  logic              normEoc, injEoc;
  logic [NUM_CH-1:0] curBit;

  function automatic logic [CH_W-1:0] lowIdx(input logic [NUM_CH-1:0] m);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (m[i]) r = CH_W'(i);
    end
    return r;
  endfunction

  assign normActive = (|normPend) || (state == ST_CONV && !curInj);
  assign injActive  = (|injPend)  || (state == ST_CONV && curInj);
  assign doneHit    = (state == ST_CONV) && convDone && !cfg.powerDown;
  assign trigNorm   = !cfg.powerDown && !normActive &&
                      (cfg.swStart || (cfg.timerEn && timerTick));
  assign trigInj    = !cfg.powerDown && !injActive && cfg.swInject;
  assign curBit     = NUM_CH'(1) << curIdx;

  // Next pending sets: completion, reload, triggers, power-down.
  always_comb begin
    normPendN = normPend;
    injPendN  = injPend;
    normEoc   = 1'b0;
    injEoc    = 1'b0;
    if (doneHit) begin
      if (curInj) begin
        injPendN = injPend & ~curBit;
        if (injPendN == '0) injEoc = 1'b1;
      end else begin
        normPendN = normPend & ~curBit;
        if (normPendN == '0) begin
          normEoc = 1'b1;
          if (cfg.scanMode) normPendN = cfg.normMask;
        end
      end
    end
    if (trigNorm) normPendN = cfg.normMask;
    if (trigInj)  injPendN  = cfg.injMask;
    if (cfg.powerDown) begin
      normPendN = '0;
      injPendN  = '0;
    end
  end

  assign pickInj = |injPend;
  assign pickIdx = pickInj ? lowIdx(injPend) : lowIdx(normPend);
  assign launch  = (state == ST_IDLE) && !cfg.powerDown &&
                   ((|injPend) || (|normPend));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      normPend  <= '0;
      injPend   <= '0;
      curIdx    <= '0;
      curInj    <= 1'b0;
      convStart <= 1'b0;
      convChan  <= '0;
      extSel    <= '0;
    end else begin
      normPend  <= normPendN;
      injPend   <= injPendN;
      convStart <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (launch) begin
            state     <= ST_CONV;
            convStart <= 1'b1;
            curIdx    <= pickIdx;
            curInj    <= pickInj;
            if (pickIdx >= CH_W'(NUM_INT)) begin
              convChan <= CONV_CH_W'(NUM_INT);
              extSel   <= SEL_W'(pickIdx - CH_W'(NUM_INT));
            end else begin
              convChan <= CONV_CH_W'(pickIdx);
              extSel   <= '0;
            end
          end
        end
        ST_CONV: begin
          if (cfg.powerDown || convDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.resWr   = doneHit;
  assign strobe.resInj  = curInj;
  assign strobe.resChan = curIdx;
  assign strobe.resData = convData;
  assign strobe.normEoc = normEoc;
  assign strobe.injEoc  = injEoc;
  assign strobe.busy    = (state == ST_CONV) || (|normPend) || (|injPend);
endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  seq_strobe_t       strobe,
  output seq_cfg_t          cfg,
  output logic [NUM_CMP-1:0] alarm
);
  logic              scanQ, alignQ, pdnQ, timerQ;
  logic [NUM_CH-1:0] normMaskQ, injMaskQ;
  logic              eocQ, injEocQ;
  logic [NUM_CMP-1:0] alarmQ, cmpHit, clrAlm;
  logic [DATA_W-1:0] cmpLow  [NUM_CMP];
  logic [DATA_W-1:0] cmpHigh [NUM_CMP];
  logic [CH_W-1:0]   cmpChan [NUM_CMP];
  logic [1:0]        cmpMode [NUM_CMP];
  logic [DATA_W-1:0] resVal  [NUM_RES];
  logic              resInjQ [NUM_RES];
  logic [$clog2(NUM_RES)-1:0] slot;
  logic [31:0]       rdNext;
  logic              wrStat;
  logic              unusedWdataHi;

  assign unusedWdataHi = ^regWdata[31:CMP_TOP];

  function automatic logic [RES_W-1:0] alignRes(input logic [DATA_W-1:0] d,
                                                input logic left);
    return left ? {d, PAD_W'(0)} : {PAD_W'(0), d};
  endfunction

  assign wrStat = regWr && (regAddr == ADDR_W'(A_STAT));
  assign clrAlm = wrStat ? regWdata[STAT_ALM +: NUM_CMP] : '0;
  assign slot   = (strobe.resChan >= CH_W'(NUM_INT)) ?
                  $clog2(NUM_RES)'(NUM_INT) : $clog2(NUM_RES)'(strobe.resChan);

  // Window comparators, one per configured slot.
  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    logic chanMatch, above, below;
    assign chanMatch = strobe.resWr && (strobe.resChan == cmpChan[k]);
    assign above     = strobe.resData > cmpHigh[k];
    assign below     = strobe.resData < cmpLow[k];
    always_comb begin
      case (cmp_mode_t'(cmpMode[k]))
        CMP_GT:   cmpHit[k] = chanMatch && above;
        CMP_LT:   cmpHit[k] = chanMatch && below;
        CMP_OUTR: cmpHit[k] = chanMatch && (above || below);
        default:  cmpHit[k] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanQ     <= 1'b0;
      alignQ    <= 1'b0;
      pdnQ      <= 1'b0;
      timerQ    <= 1'b0;
      normMaskQ <= '0;
      injMaskQ  <= '0;
      eocQ      <= 1'b0;
      injEocQ   <= 1'b0;
      alarmQ    <= '0;
      for (int k = 0; k < NUM_CMP; k++) begin
        cmpLow[k]  <= '0;
        cmpHigh[k] <= '0;
        cmpChan[k] <= '0;
        cmpMode[k] <= '0;
      end
      for (int r = 0; r < NUM_RES; r++) begin
        resVal[r]  <= '0;
        resInjQ[r] <= 1'b0;
      end
    end else begin
      if (regWr && regAddr == ADDR_W'(A_CTRL)) begin
        scanQ  <= regWdata[0];
        alignQ <= regWdata[1];
        pdnQ   <= regWdata[2];
        timerQ <= regWdata[3];
      end
      if (regWr && regAddr == ADDR_W'(A_NMASK)) normMaskQ <= regWdata[NUM_CH-1:0];
      if (regWr && regAddr == ADDR_W'(A_IMASK)) injMaskQ  <= regWdata[NUM_CH-1:0];
      for (int k = 0; k < NUM_CMP; k++) begin
        if (regWr && regAddr == ADDR_W'(A_CMP + k)) begin
          cmpLow[k]  <= regWdata[DATA_W-1:0];
          cmpHigh[k] <= regWdata[CMP_HI_LSB +: DATA_W];
          cmpChan[k] <= regWdata[CMP_CH_LSB +: CH_W];
          cmpMode[k] <= regWdata[CMP_MODE_LSB +: 2];
        end
      end
      eocQ    <= (eocQ    && !(wrStat && regWdata[1])) || strobe.normEoc;
      injEocQ <= (injEocQ && !(wrStat && regWdata[2])) || strobe.injEoc;
      alarmQ  <= (alarmQ & ~clrAlm) | cmpHit;
      for (int r = 0; r < NUM_RES; r++) begin
        if (strobe.resWr && slot == $clog2(NUM_RES)'(r)) begin
          resVal[r]  <= strobe.resData;
          resInjQ[r] <= strobe.resInj;
        end
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (regAddr == ADDR_W'(A_CTRL))  rdNext = {28'b0, timerQ, pdnQ, alignQ, scanQ};
    if (regAddr == ADDR_W'(A_NMASK)) rdNext = 32'(normMaskQ);
    if (regAddr == ADDR_W'(A_IMASK)) rdNext = 32'(injMaskQ);
    if (regAddr == ADDR_W'(A_STAT)) begin
      rdNext[0] = strobe.busy;
      rdNext[1] = eocQ;
      rdNext[2] = injEocQ;
      rdNext[STAT_ALM +: NUM_CMP] = alarmQ;
    end
    for (int k = 0; k < NUM_CMP; k++) begin
      if (regAddr == ADDR_W'(A_CMP + k))
        rdNext = 32'({cmpMode[k], cmpChan[k], cmpHigh[k], cmpLow[k]});
    end
    for (int r = 0; r < NUM_RES; r++) begin
      if (regAddr == ADDR_W'(A_RES + r))
        rdNext = {15'b0, resInjQ[r], alignRes(resVal[r], alignQ)};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRdata <= '0;
    else       regRdata <= rdNext;
  end

  assign alarm        = alarmQ;
  assign cfg.scanMode = scanQ;
  assign cfg.powerDown = pdnQ;
  assign cfg.timerEn  = timerQ;
  assign cfg.normMask = normMaskQ;
  assign cfg.injMask  = injMaskQ;
  assign cfg.swStart  = regWr && regAddr == ADDR_W'(A_CMD) && regWdata[0];
  assign cfg.swInject = regWr && regAddr == ADDR_W'(A_CMD) && regWdata[1];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic                 timerTick,
  output logic                 convStart,
  output logic [CONV_CH_W-1:0] convChan,
  output logic [SEL_W-1:0]     extSel,
  input  logic                 convDone,
  input  logic [DATA_W-1:0]    convData,
  output logic [NUM_CMP-1:0]   alarm,
  output logic                 busy
);
  seq_cfg_t    cfg;
  seq_strobe_t strobe;

  adc_seq_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .strobe   (strobe),
    .cfg      (cfg),
    .alarm    (alarm)
  );

  adc_seq_ctrl_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .cfg       (cfg),
    .timerTick (timerTick),
    .convDone  (convDone),
    .convData  (convData),
    .convStart (convStart),
    .convChan  (convChan),
    .extSel    (extSel),
    .strobe    (strobe)
  );

  assign busy = strobe.busy;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 convStart,
  input logic [CONV_CH_W-1:0] convChan,
  input logic [SEL_W-1:0]     extSel,
  input logic                 busy,
  input logic                 pdn,
  input logic [NUM_CMP-1:0]   alarm,
  input logic                 regWr,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [NUM_CMP-1:0]   clrBits
);
  logic [NUM_CMP-1:0] clrMask;
  assign clrMask = (regWr && regAddr == ADDR_W'(A_STAT)) ? clrBits : '0;

  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (busy && convChan <= CONV_CH_W'(NUM_INT)));

  // R8
  pdn_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(pdn) |-> !convStart);

  // R4
  int_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && convChan != CONV_CH_W'(NUM_INT)) |-> (extSel == '0));

  // R6
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(alarm) & ~$past(clrMask)) & ~alarm) == '0));
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .convStart (convStart),
  .convChan  (convChan),
  .extSel    (extSel),
  .busy      (busy),
  .pdn       (cfg.powerDown),
  .alarm     (alarm),
  .regWr     (regWr),
  .regAddr   (regAddr),
  .clrBits   (regWdata[11:8])
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  import adc_seq_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [ADDR_W-1:0]    regAddr = '0;
  logic                 regWr = 1'b0;
  logic [31:0]          regWdata = '0;
  logic [31:0]          regRdata;
  logic                 timerTick = 1'b0;
  logic                 convStart;
  logic [CONV_CH_W-1:0] convChan;
  logic [SEL_W-1:0]     extSel;
  logic                 convDone = 1'b0;
  logic [DATA_W-1:0]    convData = '0;
  logic [NUM_CMP-1:0]   alarm;
  logic                 busy;

  adc_seq_ctrl dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .timerTick(timerTick),
    .convStart(convStart), .convChan(convChan), .extSel(extSel),
    .convDone(convDone), .convData(convData), .alarm(alarm), .busy(busy)
  );

  int tests = 0;
  int fails = 0;
  int convLog [0:1023];
  int logCount = 0;
  int lat = 0;
  int curI = 0;
  int seenIdx;

  function automatic int model(input int i);
    return (i * 41 + 7) & 1023;
  endfunction

  // Behavioural converter: done three cycles after the start is sampled.
  always @(posedge clk) begin
    convDone <= 1'b0;
    if (convStart) begin
      seenIdx = (convChan == CONV_CH_W'(NUM_INT)) ? NUM_INT + int'(extSel) : int'(convChan);
      convLog[logCount & 1023] <= seenIdx;
      logCount <= logCount + 1;
      curI <= seenIdx;
      lat <= 3;
    end else if (lat > 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        convDone <= 1'b1;
        convData <= DATA_W'(model(curI));
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    regWr = 1'b1; regAddr = ADDR_W'(a); regWdata = 32'(d);
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    regAddr = ADDR_W'(a);
    @(negedge clk);
    d = int'(regRdata);
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v, base, n, bad, exp, lastExt;
    int masks [4];
    masks[0] = 32'h1200A5; masks[1] = 32'hFF0000;
    masks[2] = 32'h00FFFF; masks[3] = 32'h800001;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    check("R10 convStart", int'(convStart), 0);
    check("R10 busy", int'(busy), 0);
    check("R10 alarm", int'(alarm), 0);
    rd(A_STAT, v); check("R10 status", v, 0);
    rd(A_RES, v);  check("R10 result0", v, 0);
    rd(A_NMASK, v); check("R10 mask", v, 0);

    // R1/R4/R5 one-shot mask sweep
    foreach (masks[m]) begin
      wr(A_CTRL, 0);
      wr(A_NMASK, masks[m]);
      wr(A_STAT, 32'h6);
      base = logCount;
      wr(A_CMD, 1);
      waitIdle();
      n = 0; bad = 0; lastExt = -1;
      for (int c = 0; c < NUM_CH; c++) begin
        if (masks[m][c]) begin
          if (convLog[(base + n) & 1023] != c) bad++;
          n++;
          if (c >= NUM_INT) lastExt = c;
        end
      end
      check("R1 chain length", logCount - base, n);
      check("R1 ascending order", bad, 0);
      for (int c = 0; c < NUM_INT; c++) begin
        if (masks[m][c]) begin
          rd(A_RES + c, v); check("R5 right-aligned result", v, model(c));
        end
      end
      if (lastExt >= 0) begin
        rd(A_RES + NUM_INT, v); check("R4 shared external result", v, model(lastExt));
      end
      rd(A_STAT, v); check("R2 end-of-chain flag", v & 2, 2);
      repeat (20) @(negedge clk);
      check("R1 one-shot stops", logCount - base, n);
    end

    // R5 left alignment
    wr(A_CTRL, 2);
    rd(A_RES, v); check("R5 left-aligned result", v, model(0) << 6);
    rd(A_RES + NUM_INT, v); check("R5 left-aligned external", v, model(23) << 6);

    // R2 scan mode
    wr(A_CTRL, 1);
    wr(A_NMASK, 32'h6);
    base = logCount;
    wr(A_CMD, 1);
    while (logCount - base < 7) @(negedge clk);
    wr(A_CTRL, 0);
    waitIdle();
    n = logCount - base; bad = 0;
    for (int i = 0; i < n; i++) if (convLog[(base + i) & 1023] != ((i % 2) ? 2 : 1)) bad++;
    check("R2 scan repeats pattern", bad, 0);
    check("R2 scan ends on whole chain", n % 2, 0);

    // R3 injection preempting a normal chain
    wr(A_NMASK, 32'h1E);
    wr(A_IMASK, 32'h600);
    wr(A_STAT, 32'h6);
    base = logCount;
    wr(A_CMD, 1);
    while (logCount - base < 1) @(negedge clk);
    wr(A_CMD, 2);
    waitIdle();
    check("R3 total conversions", logCount - base, 6);
    check("R3 order slot0", convLog[(base + 0) & 1023], 1);
    check("R3 order slot1", convLog[(base + 1) & 1023], 9);
    check("R3 order slot2", convLog[(base + 2) & 1023], 10);
    check("R3 order slot3", convLog[(base + 3) & 1023], 2);
    check("R3 order slot5", convLog[(base + 5) & 1023], 4);
    rd(A_RES + 9, v); check("R3 injected flag set", v, (1 << 16) | model(9));
    rd(A_RES + 1, v); check("R3 normal flag clear", v, model(1));
    rd(A_STAT, v); check("R3 both end flags", v & 6, 6);

    // R6 comparators: ch2 = 89, ch5 = 212
    wr(A_CMP + 0, 50 << 10 | 2 << 20 | 1 << 25);
    wr(A_CMP + 1, 100 | 2 << 20 | 2 << 25);
    wr(A_CMP + 2, 100 | 200 << 10 | 5 << 20 | 3 << 25);
    wr(A_CMP + 3, 300 << 10 | 5 << 20 | 1 << 25);
    rd(A_CMP + 2, v); check("R6 config readback", v, 100 | 200 << 10 | 5 << 20 | 3 << 25);
    check("R6 no alarm before run", int'(alarm), 0);
    wr(A_NMASK, 32'h24);
    wr(A_CMD, 1);
    waitIdle();
    check("R6 alarms after run", int'(alarm), 7);
    rd(A_STAT, v); check("R6 status alarm bits", (v >> 8) & 15, 7);
    wr(A_STAT, 32'h100);
    check("R6 write-one clears one alarm", int'(alarm), 6);
    wr(A_CMD, 1);
    waitIdle();
    check("R6 alarm re-raised", int'(alarm), 7);
    wr(A_STAT, 32'hF00);

    // R7 timer trigger
    wr(A_CTRL, 0);
    wr(A_NMASK, 32'h1);
    base = logCount;
    @(negedge clk); timerTick = 1'b1; @(negedge clk); timerTick = 1'b0;
    repeat (20) @(negedge clk);
    check("R7 tick ignored when disabled", logCount - base, 0);
    wr(A_CTRL, 8);
    @(negedge clk); timerTick = 1'b1; @(negedge clk); timerTick = 1'b0;
    waitIdle();
    check("R7 tick starts chain", logCount - base, 1);
    check("R7 tick chain channel", convLog[base & 1023], 0);

    // R8 power-down
    wr(A_CTRL, 1);
    wr(A_NMASK, 32'h3);
    base = logCount;
    wr(A_CMD, 1);
    while (logCount - base < 3) @(negedge clk);
    wr(A_CTRL, 5);
    repeat (2) @(negedge clk);
    exp = logCount;
    repeat (30) @(negedge clk);
    check("R8 no starts in power-down", logCount, exp);
    check("R8 busy low in power-down", int'(busy), 0);
    wr(A_CMD, 1);
    repeat (20) @(negedge clk);
    check("R8 start ignored in power-down", logCount, exp);
    wr(A_CTRL, 0);
    repeat (20) @(negedge clk);
    check("R8 pending discarded", logCount, exp);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule